// File: doc/BRIEF.md
# Priority-Programmable Bus Arbiter

This block decides which of eight bus masters owns one shared slave port. Every master raises a request line that stays high for the whole of its bus cycle. The block answers with a one-hot grant vector and the binary index of the granted master. The surrounding interconnect uses that index to steer its data and address multiplexers.

Each master has a 2-bit priority level, and level 3 is the most urgent. The eight levels sit side by side in the low 16 bits of word 0 of a small configuration file inside the block. The file holds sixteen 32-bit words and has its own simple slave port. A master with a higher level always wins over a master with a lower level. Masters that share the winning level take turns in round-robin order, and each level keeps its own rotation pointer.

A granted master keeps the port until it drops its request. A burst with idle gaps between its beats therefore stays whole. A change to the levels takes effect at the next arbitration and never cancels a grant that is already active.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset `gnt_o` is all zeros, `gnt_idx_o` is 0, all sixteen configuration words read as 0, and every level's rotation pointer selects master 0 first.
- R2: `gnt_o` has at most one bit set. While a bit is set, `gnt_idx_o` is the position of that bit; otherwise `gnt_idx_o` is 0.
- R3: A grant appears on the clock edge after the request is seen, and it only goes to a master whose request was high in the cycle before. If no master requests in a cycle, `gnt_o` is zero after the next edge.
- R4: The level of master i is bits [2i+1:2i] of configuration word 0. When the block arbitrates, the winner has the numerically highest level among the requesting masters.
- R5: Among requesters at the winning level, the search starts at that level's pointer and moves upward with wrap-around. After a grant to master m at level L, the pointer for level L becomes (m+1) mod 8.
- R6: While the granted master keeps its request high, the grant does not change, whatever other masters request. The block arbitrates again at the edge that sees that request low, and may grant another master directly.
- R7: Configuration access: `cfg_word_i` selects one of 16 words. A strobe is answered with `cfg_ack_o` one cycle later, for exactly one cycle. A write stores all 32 bits at that edge, and `cfg_rdata_o` carries the addressed word while `cfg_ack_o` is high.
- R8: A write to word 0 leaves an active grant untouched and applies from the next arbitration onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request (cycle-valid) per master |
| gnt_o | output | 8 | One-hot grant |
| gnt_idx_o | output | 3 | Index of the granted master |
| cfg_stb_i | input | 1 | Configuration access strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_word_i | input | 4 | Configuration word index (byte address bits 5:2) |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| cfg_ack_o | output | 1 | Configuration access acknowledge |

## Verification
The bench builds the block with its default eight masters, four levels and sixteen configuration words. This is small enough to apply all 256 request patterns under each of 24 level words. For every pattern, the bench drains the requesters one at a time and checks each grant against a model that computes the winner arithmetically, with its own copy of the four rotation pointers. Directed sequences cover grant hold against a higher-level requester, a level rewrite during a held grant, and readback of every configuration word.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned N_MST     = 8;
  localparam int unsigned LVL_W     = 2;
  localparam int unsigned CFG_WORDS = 16;
  localparam int unsigned CFG_DW    = 32;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs #(
  parameter int unsigned WORDS  = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned PRIO_W = 16,
  localparam int unsigned IW    = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [IW-1:0]     word_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ack_o,
  output logic [PRIO_W-1:0] prio_o
);
  logic [DW-1:0] regs_q [WORDS];
  logic          ack_q;
  logic [DW-1:0] rdata_q;
  logic          acc;

  assign acc = stb_i && !ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= acc;
      if (acc) rdata_q <= we_i ? wdata_i : regs_q[word_i];
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (acc && we_i && word_i == IW'(g))     regs_q[g] <= wdata_i;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
  assign prio_o  = regs_q[0][PRIO_W-1:0];
endmodule

// File: rtl/arb_level_sel.sv
module arb_level_sel #(
  parameter int unsigned N      = 8,
  parameter int unsigned LW     = 2,
  localparam int unsigned NLVL  = 1 << LW
) (
  input  logic [N-1:0]    req_i,
  input  logic [N*LW-1:0] lvl_i,
  output logic [N-1:0]    cand_o,
  output logic [LW-1:0]   top_o
);
  logic [N-1:0] match [NLVL];

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_mst
      assign match[l][i] = req_i[i] && (lvl_i[i*LW +: LW] == LW'(l));
    end
  end

  always_comb begin
    top_o = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (|match[l]) top_o = LW'(l);
    end
    cand_o = match[top_o];
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N   = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] start_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(start_i) + k) % N;
      if (!valid_o && cand_i[j]) begin
        valid_o = 1'b1;
        idx_o   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned N      = N_MST,
  parameter int unsigned LW     = LVL_W,
  parameter int unsigned WORDS  = CFG_WORDS,
  parameter int unsigned DW     = CFG_DW,
  localparam int unsigned IW    = $clog2(N),
  localparam int unsigned WIW   = $clog2(WORDS),
  localparam int unsigned NLVL  = 1 << LW,
  localparam int unsigned PW    = N * LW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  output logic [N-1:0]   gnt_o,
  output logic [IW-1:0]  gnt_idx_o,
  input  logic           cfg_stb_i,
  input  logic           cfg_we_i,
  input  logic [WIW-1:0] cfg_word_i,
  input  logic [DW-1:0]  cfg_wdata_i,
  output logic [DW-1:0]  cfg_rdata_o,
  output logic           cfg_ack_o
);
  logic [PW-1:0] prio;
  logic [N-1:0]  cand;
  logic [LW-1:0] top_lvl;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] ptr_q [NLVL];
  logic [N-1:0]  gnt_q;
  logic [IW-1:0] own_q;
  logic          busy_q;
  logic          hold;

  arb_cfg_regs #(.WORDS(WORDS), .DW(DW), .PRIO_W(PW)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (cfg_stb_i),
    .we_i    (cfg_we_i),
    .word_i  (cfg_word_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .ack_o   (cfg_ack_o),
    .prio_o  (prio)
  );

  arb_level_sel #(.N(N), .LW(LW)) u_lvl (
    .req_i  (req_i),
    .lvl_i  (prio),
    .cand_o (cand),
    .top_o  (top_lvl)
  );

  arb_rr_pick #(.N(N)) u_pick (
    .cand_i  (cand),
    .start_i (ptr_q[top_lvl]),
    .valid_o (pick_vld),
    .idx_o   (pick_idx)
  );

  // owner keeps the port while its cycle-valid stays high
  assign hold = busy_q && req_i[own_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      own_q  <= '0;
      busy_q <= 1'b0;
    end else if (!hold) begin
      if (pick_vld) begin
        gnt_q  <= N'(1) << pick_idx;
        own_q  <= pick_idx;
        busy_q <= 1'b1;
      end else begin
        gnt_q  <= '0;
        own_q  <= '0;
        busy_q <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < NLVL; l++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q[l] <= '0;
      else if (!hold && pick_vld && top_lvl == LW'(l))
        ptr_q[l] <= (pick_idx == IW'(N - 1)) ? '0 : pick_idx + 1'b1;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_idx_o = own_q;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  req_i,
  input logic [N-1:0]  gnt_o,
  input logic [IW-1:0] gnt_idx_o,
  input logic          cfg_stb_i,
  input logic          cfg_ack_o
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R2
  gnt_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> gnt_o[gnt_idx_o]);

  // R3
  gnt_to_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> (gnt_o == '0));

  // R3
  gnt_from_past_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> ((gnt_o == '0) || ((gnt_o & $past(req_i)) != '0)));

  // R6
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != '0) |=> (gnt_o == $past(gnt_o)));

  // R7
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ack_o |=> !cfg_ack_o);

  // R7
  ack_from_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stb_i && !cfg_ack_o) |=> cfg_ack_o);
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .gnt_o     (gnt_o),
  .gnt_idx_o (gnt_idx_o),
  .cfg_stb_i (cfg_stb_i),
  .cfg_ack_o (cfg_ack_o)
);

// File: tb/tb_prio_bus_arbiter.sv
`timescale 1ns/1ps
module tb_prio_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [7:0]  gnt;
  logic [2:0]  gidx;
  logic        stb = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  word = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int m_ptr [4];

  always #2 clk = ~clk;

  prio_bus_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt), .gnt_idx_o(gidx),
    .cfg_stb_i(stb), .cfg_we_i(we), .cfg_word_i(word), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .cfg_ack_o(ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_acc(input bit wr, input int idx, input logic [31:0] d, output logic [31:0] q, output bit ack_ok);
    @(negedge clk);
    stb = 1'b1; we = wr; word = 4'(idx); wdata = d;
    @(negedge clk);
    ack_ok = (ack === 1'b1);
    q = rdata;
    stb = 1'b0; we = 1'b0;
    @(negedge clk);
    ack_ok = ack_ok && (ack === 1'b0);
  endtask

  function automatic int lvl_of(input logic [15:0] w, input int m);
    return int'(w[2*m +: 2]);
  endfunction

  function automatic int model_pick(input logic [7:0] r, input logic [15:0] w, output int lvl);
    lvl = -1;
    for (int i = 0; i < 8; i++) if (r[i] && lvl_of(w, i) > lvl) lvl = lvl_of(w, i);
    if (lvl < 0) return -1;
    for (int k = 0; k < 8; k++) begin
      int j;
      j = (m_ptr[lvl] + k) % 8;
      if (r[j] && lvl_of(w, j) == lvl) return j;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    bit          aok;
    for (int l = 0; l < 4; l++) m_ptr[l] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(gnt === 8'h00, "R1 gnt after reset", 32'(gnt), 0);
    chk(gidx === 3'd0, "R1 idx after reset", 32'(gidx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      cfg_acc(1'b0, i, 32'h0, q, aok);
      chk(q === 32'h0, "R1 config word zero after reset", q, 0);
    end

    // R7: every word written and read back, ack timing
    for (int i = 0; i < 16; i++) begin
      cfg_acc(1'b1, i, (32'h0101_0101 * i) ^ 32'hA5C3_0000 ^ 32'(i << 7), q, aok);
      chk(aok, "R7 ack one cycle after write strobe", 32'(aok), 1);
    end
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e;
      e = (32'h0101_0101 * i) ^ 32'hA5C3_0000 ^ 32'(i << 7);
      cfg_acc(1'b0, i, 32'h0, q, aok);
      chk(aok && q === e, "R7 config readback", q, e);
    end

    // R4 R5 R2 R3: all request patterns under a set of level words
    for (int k = 0; k < 24; k++) begin
      logic [15:0] w;
      w = (k == 22) ? 16'hFFFF : 16'((k * 16'h9E37) + (k * k * 16'h1234));
      cfg_acc(1'b1, 0, {16'h0, w}, q, aok);
      for (int r = 0; r < 256; r++) begin
        logic [7:0] cur;
        bit ok;
        int steps;
        ok = 1'b1; steps = 0;
        cur = 8'(r);
        @(negedge clk);
        req = cur;
        forever begin
          int e, lv;
          @(negedge clk);
          e = model_pick(cur, w, lv);
          if (e < 0) begin
            if (gnt !== 8'h00 || gidx !== 3'd0) begin
              ok = 1'b0;
              $display("FAIL R3 idle grant word=%h pat=%h actual=%h expected=00", w, r[7:0], gnt);
            end
            break;
          end
          if (gnt !== (8'h01 << e) || gidx !== 3'(e)) begin
            ok = 1'b0;
            $display("FAIL R4/R5 word=%h pat=%h step=%0d actual=%h/%0d expected=%h/%0d",
                     w, r[7:0], steps, gnt, gidx, 8'h01 << e, e);
          end
          m_ptr[lv] = (e + 1) % 8;
          cur[e] = 1'b0;
          req = cur;
          steps++;
        end
        n_run++;
        if (!ok) n_fail++;
      end
    end

    // R6: hold against a higher-level requester (master 2 lvl 0, master 5 lvl 3)
    cfg_acc(1'b1, 0, 32'h0000_0C00, q, aok);
    @(negedge clk); req = 8'h04;
    @(negedge clk);
    chk(gnt === 8'h04, "R6 initial grant to master 2", 32'(gnt), 32'h04);
    req = 8'h24;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(gnt === 8'h04, "R6 grant held while request high", 32'(gnt), 32'h04);
    end
    // R8: rewrite levels during hold (master 2 lvl 3, master 7 lvl 2, master 5 lvl 0)
    req = 8'hA4;
    cfg_acc(1'b1, 0, 32'h0000_8030, q, aok);
    chk(gnt === 8'h04, "R8 level write keeps active grant", 32'(gnt), 32'h04);
    req = 8'hA0;
    @(negedge clk);
    chk(gnt === 8'h80, "R8 new levels used at next arbitration", 32'(gnt), 32'h80);
    chk(gidx === 3'd7, "R2 index of new owner", 32'(gidx), 7);
    req = 8'h20;
    @(negedge clk);
    chk(gnt === 8'h20, "R6 direct handover on request drop", 32'(gnt), 32'h20);
    req = 8'h00;
    @(negedge clk);
    chk(gnt === 8'h00, "R3 grant clears with no request", 32'(gnt), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule